// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into a framed serial bit stream on a single output line that rests at logic 1. A frame carries one low start bit, then 7 or 8 data bits in either bit order, then an optional parity bit, then one or two high stop bits. The frame shape is set by static control inputs. These inputs are changed only while the block is disabled.

Bit timing comes from an external divider. It delivers a one-clock tick per bit period, and every slot on the line, including the start bit, lasts exactly one tick period. After a character is accepted, the line stays idle until the next tick and then begins the frame. The busy flag is high from the accepting edge until the tick that closes the last stop bit. A load that arrives while the block is busy, disabled or in a non-asynchronous mode has no effect.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever busy_o is 0, txd_o is 1.
- R2: A load (ld_i=1 at a clock edge with en_i=1, mode_i[1]=1 and busy_o=0) sets busy_o at that edge. From each later tick onward, txd_o shows the next slot: a 0 start bit, the data bits, the parity bit if enabled, then the stop bits.
- R3: mode_i=2'b11 sends 8 data bits, D0..D7. mode_i=2'b10 sends 7 data bits, D0..D6. In the 7-bit case, data_i[7] affects neither the line nor the parity.
- R4: msb_first_i=0 sends D0 first. msb_first_i=1 sends the top data bit first: D7 in 8-bit mode, D6 in 7-bit mode.
- R5: With par_en_i=1, one parity bit follows the last data bit. With par_odd_i=1, the data bits plus the parity bit hold an odd number of ones; with par_odd_i=0, an even number.
- R6: stop2_i=0 gives one stop bit and stop2_i=1 gives two, both high. busy_o falls at the tick that ends the last stop bit.
- R7: A load while busy_o=1 is ignored, including a load on the same edge as the tick that ends the frame.
- R8: While en_i=0, loads are ignored. Dropping en_i mid-frame clears busy_o and returns txd_o to 1 at the next edge.
- R9: With mode_i[1]=0, loads are ignored.
- R10: A load that coincides with a tick is accepted. The idle slot before the start bit then lasts one full tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Transmitter enable |
| mode_i | input | 2 | Mode code: 2'b11 selects 8-bit, 2'b10 selects 7-bit, bit1=0 selects non-async |
| par_en_i | input | 1 | Insert parity bit |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even |
| stop2_i | input | 1 | 1 = two stop bits |
| msb_first_i | input | 1 | 1 = highest data bit first |
| tick_i | input | 1 | One-clock bit-rate tick |
| ld_i | input | 1 | Load strobe |
| data_i | input | DATA_W | Character to send |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial line, idle high |

## Verification
Two events can land on the same edge: a load strobe and a bit-rate tick. The bench forces this coincidence in two places. In the first case the block is idle, and the check confirms that the load is accepted, that no slot is consumed, and that the line stays high for a full tick period before the start bit. In the second case the load sits on the tick that ends the final stop bit, and the check confirms that busy_o drops and stays low with the line high, so the late load is never taken.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic wide;       // 1: full-width data, 0: one bit shorter
    logic par_en;
    logic par_odd;
    logic stop2;
    logic msb_first;
  } frame_cfg_t;
endpackage

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SW     = DATA_W + 5,
  parameter int CW     = $clog2(SW + 1)
) (
  input  frame_cfg_t        cfg_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SW-1:0]     img_o,
  output logic [CW-1:0]     slots_o
);
  // clear the unused top bit in short mode
  function automatic logic [DATA_W-1:0] keep_bits(logic [DATA_W-1:0] d, logic wide);
    return wide ? d : {1'b0, d[DATA_W-2:0]};
  endfunction

  function automatic logic par_bit(logic [DATA_W-1:0] d, logic odd);
    return (^d) ^ odd;
  endfunction

  // result[i] is the i-th data bit put on the line
  function automatic logic [DATA_W-1:0] order_bits(logic [DATA_W-1:0] d, logic wide, logic msb);
    logic [DATA_W-1:0] r;
    int top;
    top = wide ? DATA_W - 1 : DATA_W - 2;
    r = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (!msb) r[i] = d[i];
      else if (top - i >= 0) r[i] = d[top - i];
    end
    return r;
  endfunction

  logic [DATA_W-1:0] masked, seq;
  logic [CW-1:0]     pos;

  always_comb begin
    masked = keep_bits(data_i, cfg_i.wide);
    seq    = order_bits(masked, cfg_i.wide, cfg_i.msb_first);
    img_o  = '1;            // slot 0 idle, stop bits and padding high
    img_o[1] = 1'b0;        // start bit
    for (int i = 0; i < DATA_W; i++) begin
      if (cfg_i.wide || i < DATA_W - 1) img_o[2 + i] = seq[i];
    end
    pos = cfg_i.wide ? CW'(DATA_W + 2) : CW'(DATA_W + 1);
    if (cfg_i.par_en) begin
      img_o[pos] = par_bit(masked, cfg_i.par_odd);
      pos = pos + 1'b1;
    end
    slots_o = pos + (cfg_i.stop2 ? CW'(2) : CW'(1));
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int SW = 13,
  parameter int CW = $clog2(SW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          accept_i,
  input  logic          tick_i,
  input  logic [SW-1:0] img_i,
  input  logic [CW-1:0] slots_i,
  output logic          busy_o,
  output logic          line_o,
  output logic          last_slot_o
);
  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign line_o      = sh_q[0];
  assign last_slot_o = busy_o && (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (!en_i) begin
      busy_o <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
    end else if (!busy_o) begin
      if (accept_i) begin
        busy_o <= 1'b1;
        sh_q   <= img_i;
        cnt_q  <= slots_i;
      end
    end else if (tick_i) begin
      if (last_slot_o) begin
        busy_o <= 1'b0;
        sh_q   <= '1;
        cnt_q  <= '0;
      end else begin
        sh_q  <= {1'b1, sh_q[SW-1:1]};
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> line_o);
  // R8
  dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!busy_o && line_o));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i && en_i) |=> ($stable(sh_q) && busy_o));
  // R6
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_slot_o && tick_i && en_i) |=> !busy_o);
  // R10
  lead_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> line_o);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SW));
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              stop2_i,
  input  logic              msb_first_i,
  input  logic              tick_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int SW = DATA_W + 5;       // idle + start + data + parity + 2 stop
  localparam int CW = $clog2(SW + 1);

  frame_cfg_t    cfg;
  logic [SW-1:0] img;
  logic [CW-1:0] slots;
  logic          accept, last_slot;

  assign cfg    = '{wide: mode_i[0], par_en: par_en_i, par_odd: par_odd_i,
                    stop2: stop2_i, msb_first: msb_first_i};
  assign accept = ld_i && en_i && mode_i[1] && !busy_o;

  sertx_framer #(.DATA_W(DATA_W), .SW(SW), .CW(CW)) u_framer (
    .cfg_i(cfg), .data_i(data_i), .img_o(img), .slots_o(slots)
  );

  sertx_shifter #(.SW(SW), .CW(CW)) u_shifter (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .accept_i(accept), .tick_i(tick_i),
    .img_i(img), .slots_i(slots), .busy_o(busy_o), .line_o(txd_o),
    .last_slot_o(last_slot)
  );

  // R9
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(mode_i[1]) && $past(ld_i) && $past(en_i)));
  // R7
  end_ld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_slot && tick_i) |=> !busy_o);
endmodule

// File: tb/sertx_top_test.sv
`timescale 1ns/1ps
module sertx_top_test;
  localparam int TP = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, tick = 1'b0, ld = 1'b0;
  logic [1:0] mode = 2'b11;
  logic pe = 1'b0, odd = 1'b0, st2 = 1'b0, msb = 1'b0;
  logic [7:0] data = 8'h00;
  logic busy, line;
  int checks = 0, errors = 0, cyc = 0;
  logic was_tick = 1'b0;

  always #10 clk = ~clk;

  sertx_top #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .par_en_i(pe),
    .par_odd_i(odd), .stop2_i(st2), .msb_first_i(msb), .tick_i(tick),
    .ld_i(ld), .data_i(data), .busy_o(busy), .txd_o(line)
  );

  // {mode[1:0], par_en, odd, stop2, msb, data[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {6'b110000, 8'hA5}, {6'b110001, 8'h3C}, {6'b100000, 8'hC1},
    {6'b101001, 8'hF3}, {6'b111110, 8'h00}, {6'b111011, 8'hFF},
    {6'b101110, 8'h80}, {6'b100011, 8'h4E}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    was_tick = tick;
    cyc++;
    tick = (cyc % TP == 0);
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected < 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int exp_len(input logic [13:0] v);
    int n;
    n = (v[13:12] == 2'b11) ? 8 : 7;
    return 1 + n + int'(v[11]) + 1 + int'(v[9]);
  endfunction

  // expected line value in frame slot k (0 = start bit)
  function automatic logic exp_bit(input logic [13:0] v, input int k);
    int n, ones;
    n = (v[13:12] == 2'b11) ? 8 : 7;
    if (k == 0) return 1'b0;
    if (k <= n) return v[8] ? v[n - k] : v[k - 1];
    if (v[11] && k == n + 1) begin
      ones = 0;
      for (int i = 0; i < n; i++) ones += int'(v[i]);
      return logic'(ones % 2) ^ v[10];
    end
    return 1'b1;
  endfunction

  task automatic run_frame(input logic [13:0] v, input bit mid_ld, input bit align,
                           input bit end_ld, input string tag);
    int L, k, lat, guard;
    bit bad, end_ok, mid_done;
    logic last;
    logic [11:0] got, expv;
    en = 0; step();
    {mode, pe, odd, st2, msb} = v[13:8];
    en = 1; step();
    if (align) while (tick !== 1'b1) step();
    else while (tick === 1'b1) step();
    data = v[7:0]; ld = 1; step(); ld = 0;
    chk(busy === 1'b1 && line === 1'b1, {"R2 accept ", tag}, {14'h0, busy, line}, 16'h3);
    L = exp_len(v); k = 0; lat = 0; guard = 0;
    bad = 0; end_ok = 0; mid_done = 0; last = 1'b1;
    got = '1; expv = '1;
    for (int i = 0; i < L; i++) expv[i] = exp_bit(v, i);
    while (k <= L && guard < TP * 20) begin
      ld = 1'b0;
      if (mid_ld && k == 2 && !mid_done) begin ld = 1'b1; data = ~v[7:0]; mid_done = 1; end
      if (end_ld && k == L && tick === 1'b1) ld = 1'b1;
      step(); guard++;
      if (k == 0) lat++;
      if (was_tick) begin
        k++;
        if (k <= L) begin got[k-1] = line; if (busy !== 1'b1) bad = 1; end
        else end_ok = (busy === 1'b0 && line === 1'b1);
        last = line;
      end else if (line !== last) bad = 1;
    end
    ld = 1'b0;
    chk(got == expv && !bad, {"R3 R4 R5 frame ", tag}, {4'h0, got}, {4'h0, expv});
    chk(end_ok, {"R6 busy falls at last stop ", tag}, {15'h0, end_ok}, 16'h1);
    if (align) chk(lat == TP, "R10 idle slot on tick load", 16'(lat), 16'(TP));
    if (end_ld) begin
      step(); step();
      chk(busy === 1'b0 && line === 1'b1, "R7 load on final tick ignored", {14'h0, busy, line}, 16'h1);
    end
  endtask

  initial begin
    rst_n = 0;
    step(); step();
    chk(busy === 1'b0 && line === 1'b1, "R1 reset state", {14'h0, busy, line}, 16'h1);
    rst_n = 1; step();
    chk(busy === 1'b0 && line === 1'b1, "R1 idle after reset", {14'h0, busy, line}, 16'h1);

    for (int i = 0; i < 8; i++) run_frame(VEC[i], 1'b0, 1'b0, 1'b0, $sformatf("vec%0d", i));

    // R7: load mid-frame with inverted data must not disturb the frame
    run_frame({6'b111100, 8'h96}, 1'b1, 1'b0, 1'b0, "R7 mid load");
    // R10: load on a tick edge while idle
    run_frame({6'b110000, 8'h5A}, 1'b0, 1'b1, 1'b0, "R10 aligned");
    // R7: load on the closing tick of the frame
    run_frame({6'b100101, 8'h33}, 1'b0, 1'b0, 1'b1, "R7 end load");

    // R8: enable low ignores loads
    en = 0; step();
    ld = 1; data = 8'h11; step(); ld = 0; step();
    chk(busy === 1'b0 && line === 1'b1, "R8 load while disabled", {14'h0, busy, line}, 16'h1);
    // R8: disable mid-frame
    {mode, pe, odd, st2, msb} = 6'b110000;
    en = 1; step();
    ld = 1; data = 8'h00; step(); ld = 0;
    for (int i = 0; i < 7; i++) step();
    chk(busy === 1'b1, "R8 frame running before disable", {15'h0, busy}, 16'h1);
    en = 0; step();
    chk(busy === 1'b0 && line === 1'b1, "R8 disable mid-frame", {14'h0, busy, line}, 16'h1);

    // R9: non-async mode code rejects loads
    mode = 2'b01; en = 1; step();
    ld = 1; data = 8'h00; step(); ld = 0;
    for (int i = 0; i < 2 * TP; i++) step();
    chk(busy === 1'b0 && line === 1'b1, "R9 load in mode 2'b01", {14'h0, busy, line}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule